// File: doc/BRIEF.md
# Presettable Binary Down Counter with Zero Detect

This block is a down counter of parameterised width (four bits by default). It counts strobes, reloads from a parallel preset value on request, and flags the all-zero count on a dedicated output. In single-stage use the zero output is wired back to the load request. The counter then produces one zero indication every N strobes, where N is the preset value. In a chain it serves as the most significant stage. It is advanced by a lower stage's borrow and reloaded from a load line shared with the lower stages. It has no feedback input of its own, so it can only be the top stage.

The block runs on one system clock. A strobe is a count request that is sampled on a rising edge. A load request acts on any rising edge, whether or not a strobe arrives with it. When a load and a strobe arrive in the same edge, the reload consumes that strobe. This keeps the divide-by-N period exact when strobes arrive on every clock. A preset of zero is a forbidden setting. Loading it raises an error flag, and the counter then rests at zero instead of wrapping. The block has no data stream, so every pin is a plain control or status signal.

Top module: `presettable_dn_counter`

## Requirements
- R1: While rst_n is low, count_o is 0, zero_o is 1 and err_o is 0. A zero output loop-back therefore performs a preset on the first edge after reset.
- R2: On an edge with load_i high and strobe_i low, count_o becomes preset_i.
- R3: On an edge with load_i high, strobe_i high and preset_i nonzero, count_o becomes preset_i minus 1. The load takes priority over a plain decrement.
- R4: On an edge with strobe_i high, load_i low and count_o nonzero, count_o decreases by exactly 1.
- R5: zero_o is 1 exactly when count_o is 0, in the same cycle.
- R6: On an edge with both strobe_i and load_i low, count_o keeps its value.
- R7: A load with preset_i equal to 0, with or without a strobe, leaves count_o at 0 and sets err_o to 1. err_o stays 1 until a load with a nonzero preset clears it on that edge.
- R8: A strobe without a load while count_o is 0 leaves count_o at 0. It never wraps to the all-ones value.
- R9: With load_i driven from zero_o and preset_i = N (1 to 2^CNT_W-1), zero_o is high for exactly one clock in every N strobes. This holds when strobes arrive on every clock and when a lower stage supplies them every M clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| strobe_i | input | 1 | Count request, sampled on the rising edge |
| load_i | input | 1 | Reload request, usually tied to zero_o or a shared chain line |
| preset_i | input | CNT_W | Binary reload value N, bit 0 least significant |
| count_o | output | CNT_W | Current count |
| zero_o | output | 1 | High while the count is zero |
| err_o | output | 1 | High after a forbidden zero preset was loaded |

## Verification
The bench builds one instance with the default CNT_W of 4. On that instance it runs the loop-back divider for every N from 1 to 15, with strobes on every clock and with strobes every third clock from a modelled lower stage. A second instance with CNT_W of 2 brings the all-ones preset within reach in a few edges. On that instance the bench also checks the reload-with-strobe corner and the rest at zero at the narrowest width.

// File: rtl/dn_cnt_pkg.sv
package dn_cnt_pkg;
  typedef enum logic [2:0] {
    OP_HOLD      = 3'd0,
    OP_LOAD      = 3'd1,
    OP_LOAD_STEP = 3'd2,
    OP_STEP      = 3'd3,
    OP_STALL     = 3'd4
  } cnt_op_e;
endpackage

// File: rtl/dn_cnt_zero_det.sv
module dn_cnt_zero_det #(
  parameter int CNT_W = 4
) (
  input  logic [CNT_W-1:0] value_i,
  output logic             is_zero_o
);
  assign is_zero_o = ~|value_i;
endmodule

// File: rtl/dn_cnt_ctrl.sv
module dn_cnt_ctrl
  import dn_cnt_pkg::*;
(
  input  logic    strobe_i,
  input  logic    load_i,
  input  logic    preset_zero_i,
  input  logic    count_zero_i,
  output cnt_op_e op_o
);
  always_comb begin
    if (load_i) begin
      // a zero preset never steps: the counter rests at zero
      if (strobe_i && !preset_zero_i) op_o = OP_LOAD_STEP;
      else                            op_o = OP_LOAD;
    end else if (strobe_i) begin
      if (count_zero_i) op_o = OP_STALL;
      else              op_o = OP_STEP;
    end else begin
      op_o = OP_HOLD;
    end
  end
endmodule

// File: rtl/dn_cnt_datapath.sv
module dn_cnt_datapath
  import dn_cnt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  cnt_op_e          op_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q <= '0;
    end else begin
      case (op_i)
        OP_LOAD:      count_q <= preset_i;
        OP_LOAD_STEP: count_q <= preset_i - ONE;
        OP_STEP:      count_q <= count_q - ONE;
        default:      count_q <= count_q;
      endcase
    end
  end

  assign count_o = count_q;

  assert_stall_keeps_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == OP_STALL) |=> (count_q == '0));
endmodule

// File: rtl/dn_cnt_err.sv
module dn_cnt_err
  import dn_cnt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  cnt_op_e op_i,
  input  logic    preset_zero_i,
  output logic    err_o
);
  logic err_q;
  logic is_load;

  assign is_load = (op_i == OP_LOAD) || (op_i == OP_LOAD_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       err_q <= 1'b0;
    else if (is_load) err_q <= preset_zero_i;
  end

  assign err_o = err_q;

  assert_err_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (is_load && !preset_zero_i) |=> !err_q);
endmodule

// File: rtl/presettable_dn_counter.sv
module presettable_dn_counter
  import dn_cnt_pkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             strobe_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] preset_i,
  output logic [CNT_W-1:0] count_o,
  output logic             zero_o,
  output logic             err_o
);
  cnt_op_e          op;
  logic             preset_zero;
  logic             count_zero;
  logic [CNT_W-1:0] count;

  dn_cnt_zero_det #(.CNT_W(CNT_W)) u_preset_zero (
    .value_i(preset_i), .is_zero_o(preset_zero));

  dn_cnt_zero_det #(.CNT_W(CNT_W)) u_count_zero (
    .value_i(count), .is_zero_o(count_zero));

  dn_cnt_ctrl u_ctrl (
    .strobe_i(strobe_i), .load_i(load_i), .preset_zero_i(preset_zero),
    .count_zero_i(count_zero), .op_o(op));

  dn_cnt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .op_i(op), .preset_i(preset_i), .count_o(count));

  dn_cnt_err u_err (
    .clk(clk), .rst_n(rst_n), .op_i(op), .preset_zero_i(preset_zero), .err_o(err_o));

  assign count_o = count;
  assign zero_o  = count_zero;

  assert_load_plain_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && !strobe_i) |=> (count_o == $past(preset_i)));

  assert_load_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && strobe_i && preset_i != '0) |=> (count_o == CNT_W'($past(preset_i) - 1'b1)));

  assert_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !load_i && count_o != '0) |=> (count_o == CNT_W'($past(count_o) - 1'b1)));

  assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    zero_o == (count_o == '0));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_i && !load_i) |=> $stable(count_o));

  assert_zero_preset_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && preset_i == '0) |=> (err_o && count_o == '0));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_i && !load_i && count_o == '0) |=> (count_o == '0));
endmodule

// File: tb/presettable_dn_counter_tb_top.sv
`timescale 1ns/1ps
module presettable_dn_counter_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // main instance, width 4
  logic       strobe = 1'b0, load_man = 1'b0, loop_en = 1'b0;
  logic [3:0] preset = '0;
  logic [3:0] count;
  logic       zero, err, load;
  assign load = loop_en ? zero : load_man;

  presettable_dn_counter #(.CNT_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe), .load_i(load),
    .preset_i(preset), .count_o(count), .zero_o(zero), .err_o(err));

  // narrow instance, width 2
  logic       strobe2 = 1'b0, load2 = 1'b0;
  logic [1:0] preset2 = '0;
  logic [1:0] count2;
  logic       zero2, err2;

  presettable_dn_counter #(.CNT_W(2)) dut_w2_i (
    .clk(clk), .rst_n(rst_n), .strobe_i(strobe2), .load_i(load2),
    .preset_i(preset2), .count_o(count2), .zero_o(zero2), .err_o(err2));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // one rising edge, then sample at the falling edge
  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; strobe = 0; load_man = 0; loop_en = 0; strobe2 = 0; load2 = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 count in reset", count, 0);
    chk("R1 zero in reset", zero, 1);
    chk("R1 err in reset", err, 0);
    rst_n = 1'b1;
    step();
    chk("R6 idle after reset", count, 0);
  endtask

  task automatic t_load();
    preset = 4'd9; load_man = 1; strobe = 0;
    step();
    chk("R2 plain load of 9", count, 9);
    chk("R5 zero low at 9", zero, 0);
    load_man = 0;
    repeat (3) step();
    chk("R6 hold at 9", count, 9);
  endtask

  task automatic t_count();
    strobe = 1; load_man = 0;
    step();
    chk("R4 decrement 9 to 8", count, 8);
    repeat (7) step();
    chk("R4 decrement to 1", count, 1);
    chk("R5 zero low at 1", zero, 0);
    step();
    chk("R4 reach 0", count, 0);
    chk("R5 zero high at 0", zero, 1);
    step();
    chk("R8 no wrap from 0", count, 0);
    chk("R8 err stays low", err, 0);
    strobe = 0;
  endtask

  task automatic t_loadstep();
    load_man = 1; strobe = 1; preset = 4'd5;
    step();
    chk("R3 load 5 with strobe", count, 4);
    preset = 4'd15;
    step();
    chk("R3 load 15 with strobe", count, 14);
    preset = 4'd1;
    step();
    chk("R3 load 1 with strobe", count, 0);
    chk("R5 zero after load 1 with strobe", zero, 1);
    load_man = 0; strobe = 0;
  endtask

  task automatic t_zero_preset();
    preset = 4'd7; load_man = 1;
    step();
    preset = 4'd0; load_man = 1; strobe = 0;
    step();
    chk("R7 zero preset count", count, 0);
    chk("R7 zero preset err", err, 1);
    load_man = 0; strobe = 1;
    repeat (3) step();
    chk("R8 strobes after zero preset", count, 0);
    chk("R7 err held", err, 1);
    load_man = 1; strobe = 1; preset = 4'd0;
    step();
    chk("R7 zero preset with strobe count", count, 0);
    chk("R7 zero preset with strobe err", err, 1);
    strobe = 0; preset = 4'd6;
    step();
    chk("R7 legal load count", count, 6);
    chk("R7 legal load clears err", err, 0);
    load_man = 0;
  endtask

  // loop-back divider; strobe every m clocks (m=1 dense)
  task automatic t_loop(input int n, input int m);
    int hits;
    int cyc;
    do_reset();
    preset = 4'(n); loop_en = 1;
    cyc = 0;
    for (int i = 0; i < 2 * n * m + 3; i++) begin
      strobe = ((cyc % m) == 0); cyc++;
      step();
    end
    hits = 0;
    for (int i = 0; i < 4 * n * m; i++) begin
      strobe = ((cyc % m) == 0); cyc++;
      step();
      if (zero) hits++;
    end
    chk($sformatf("R9 divide n=%0d m=%0d zero pulses", n, m), hits, 4);
    strobe = 0; loop_en = 0;
  endtask

  task automatic t_narrow();
    do_reset();
    @(negedge clk);
    preset2 = 2'd3; load2 = 1; strobe2 = 1;
    step();
    chk("R3 width2 load all-ones with strobe", count2, 2);
    load2 = 0;
    step();
    chk("R4 width2 step", count2, 1);
    step();
    chk("R5 width2 zero", zero2, 1);
    step();
    chk("R8 width2 no wrap", count2, 0);
    load2 = 1; strobe2 = 0;
    step();
    chk("R2 width2 plain load all-ones", count2, 3);
    load2 = 0;
  endtask

  initial begin
    t_reset();
    t_load();
    t_count();
    t_loadstep();
    t_zero_preset();
    for (int n = 1; n <= 15; n++) t_loop(n, 1);
    for (int n = 1; n <= 15; n++) t_loop(n, 3);
    t_narrow();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #400000;
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule